// File: doc/BRIEF.md
# Effective Address Base Extractor

This block decodes the addressing bytes of a memory operand: the ModRM byte, the optional SIB byte and a displacement field. From these and a snapshot of the general register file it produces two values. The first is the value of the base register alone, which a bounds unit uses as a lower limit. The second is the complete effective address, formed as base plus scaled index plus displacement.

The block runs in either a 32-bit or a 64-bit addressing mode. In 64-bit mode, two prefix extension bits widen the base and index register selectors to four bits. The block also reports how many displacement bytes the encoding carries and whether a SIB byte is present, so that a fetch stage can advance by the right amount. Encodings that cannot form a bound are flagged as invalid. These are register-direct forms and instruction-pointer-relative forms in 64-bit mode.

All results are registered. They appear one cycle after a valid input, qualified by a valid strobe.

Top module: `ea_base_decoder`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise. After reset, every output is zero.
- R2: For mod 0, 1 or 2 with r/m not 4 (and not the mod 0 / r/m 5 case), the base is register number {`rex_b`, r/m}, where r/m is ModRM bits 2:0 and mod is ModRM bits 7:6. `base_out` carries that register.
- R3: For r/m 4 with mod not 3, the base register number is {`rex_b`, SIB bits 2:0}.
- R4: With mod 0, a low base code of 5 (SIB base, or r/m in 32-bit mode) means there is no base register, whatever the value of `rex_b`. In that case `base_out` is 0 and a 4-byte displacement is used.
- R5: Mod 3 is invalid in both modes. In 64-bit mode, mod 0 with r/m 5 is also invalid. An invalid form raises `invalid` and drives `base_out` and `ea_out` to 0.
- R6: The index register number is {`rex_x`, SIB bits 5:3}. The value 4 (with `rex_x` clear) means there is no index term. With `rex_x` set, register 12 is used as the index.
- R7: The index register is shifted left by SIB bits 7:6 (a scale of 1, 2, 4 or 8) before it is added.
- R8: `disp_len` is 1 for mod 1, where `disp` bits 7:0 are sign-extended. It is 4 for mod 2 and for the no-base forms of R4, where `disp` bits 31:0 are sign-extended. Otherwise it is 0.
- R9: In 32-bit mode (`mode64` low), `rex_b` and `rex_x` are ignored. Only register bits 31:0 are used, the sum wraps at 32 bits, and both outputs are zero-extended.
- R10: `sib_present` is high exactly when mod is not 3 and r/m is 4.
- R11: `ea_out` equals base + scaled index + displacement, computed modulo 2^64 in 64-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Addressing bytes are present this cycle |
| mode64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| rex_b | input | 1 | Base selector extension bit |
| rex_x | input | 1 | Index selector extension bit |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte (used when r/m is 4) |
| disp | input | 32 | Displacement bytes, least significant first |
| regs | input | 1024 | Sixteen 64-bit registers; register n occupies bits n*64+63:n*64 |
| out_valid | output | 1 | Results below are valid |
| base_out | output | 64 | Base register value (lower bound) |
| ea_out | output | 64 | Full effective address |
| disp_len | output | 3 | Displacement length in bytes: 0, 1 or 4 |
| sib_present | output | 1 | A SIB byte belongs to the operand |
| invalid | output | 1 | Encoding cannot form a bound |

## Verification
A wrong selector, such as a dropped extension bit or a missed no-base case, shows up as a wrong `base_out` and `ea_out` in the very next valid cycle. Each decoded result is visible one cycle after its input, so every fault appears on the first operand that exercises it. A wrong length or SIB decode shows up immediately on `disp_len` or `sib_present`, which would desynchronise a downstream fetch stage. A 32-bit wrap fault shows up as nonzero upper output bits on any address that carries past bit 31.

// File: rtl/ea_base_decoder.sv
module ea_base_decoder #(
  parameter int XLEN = 64,
  parameter int NREG = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 mode64,
  input  logic                 rex_b,
  input  logic                 rex_x,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  input  logic [31:0]          disp,
  input  logic [NREG*XLEN-1:0] regs,
  output logic                 out_valid,
  output logic [XLEN-1:0]      base_out,
  output logic [XLEN-1:0]      ea_out,
  output logic [2:0]           disp_len,
  output logic                 sib_present,
  output logic                 invalid
);
  localparam int HALF = XLEN / 2;
  localparam int SELW = $clog2(NREG);

  wire [1:0] md = modrm[7:6];
  wire [2:0] rm = modrm[2:0];

  wire mem_form = md != 2'd3;
  wire has_sib  = mem_form && rm == 3'd4;
  wire [2:0] blo = has_sib ? sib[2:0] : rm;
  wire no_base  = md == 2'd0 && blo == 3'd5;
  wire rip_rel  = mode64 && md == 2'd0 && !has_sib && rm == 3'd5;
  wire bad      = !mem_form || rip_rel;

  wire [SELW-1:0] bsel = SELW'({mode64 & rex_b, blo});
  wire [SELW-1:0] isel = SELW'({mode64 & rex_x, sib[5:3]});
  wire has_idx = has_sib && isel != SELW'(4);

  wire [XLEN-1:0] breg = regs[bsel*XLEN +: XLEN];
  wire [XLEN-1:0] ireg = regs[isel*XLEN +: XLEN];

  wire [XLEN-1:0] base_v = no_base ? '0 : breg;
  wire [XLEN-1:0] idx_v  = has_idx ? (ireg << sib[7:6]) : '0;
  wire long_disp = md == 2'd2 || (md == 2'd0 && no_base);

  logic [XLEN-1:0] disp_v;
  always_comb begin
    if (md == 2'd1)  disp_v = {{(XLEN-8){disp[7]}}, disp[7:0]};
    else if (long_disp) disp_v = {{(XLEN-32){disp[31]}}, disp};
    else             disp_v = '0;
  end

  wire [2:0] dlen = !mem_form ? 3'd0 : (md == 2'd1) ? 3'd1 : long_disp ? 3'd4 : 3'd0;
  wire [XLEN-1:0] sum = base_v + idx_v + disp_v;

  wire [XLEN-1:0] base_n = bad ? '0 : mode64 ? base_v : {{HALF{1'b0}}, base_v[HALF-1:0]};
  wire [XLEN-1:0] ea_n   = bad ? '0 : mode64 ? sum    : {{HALF{1'b0}}, sum[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      base_out    <= '0;
      ea_out      <= '0;
      disp_len    <= '0;
      sib_present <= 1'b0;
      invalid     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        base_out    <= base_n;
        ea_out      <= ea_n;
        disp_len    <= dlen;
        sib_present <= has_sib;
        invalid     <= bad;
      end
    end
  end
endmodule

// File: rtl/ea_base_decoder_chk.sv
module ea_base_decoder_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            mode64,
  input logic            out_valid,
  input logic [XLEN-1:0] base_out,
  input logic [XLEN-1:0] ea_out,
  input logic [2:0]      disp_len,
  input logic            sib_present,
  input logic            invalid
);
  localparam int HALF = XLEN / 2;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R5
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> (base_out == '0 && ea_out == '0));
  // R8
  disp_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (disp_len == 3'd0 || disp_len == 3'd1 || disp_len == 3'd4));
  // R9
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode64) |=> (base_out[XLEN-1:HALF] == '0 && ea_out[XLEN-1:HALF] == '0));
  // R10
  sib_valid_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sib_present) |-> !invalid);
endmodule

bind ea_base_decoder ea_base_decoder_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
  .out_valid(out_valid), .base_out(base_out), .ea_out(ea_out),
  .disp_len(disp_len), .sib_present(sib_present), .invalid(invalid)
);

// File: tb/ea_base_decoder_bench.sv
module ea_base_decoder_bench;
  logic clk = 0, rst_n = 0, in_valid = 0, mode64 = 0, rex_b = 0, rex_x = 0;
  logic [7:0] modrm = 0, sib = 0;
  logic [31:0] disp = 0;
  logic [1023:0] regs;
  logic [63:0] rf [16];
  logic out_valid, sib_present, invalid;
  logic [63:0] base_out, ea_out;
  logic [2:0] disp_len;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always_comb for (int i = 0; i < 16; i++) regs[i*64 +: 64] = rf[i];

  ea_base_decoder u_ea_base_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
    .rex_b(rex_b), .rex_x(rex_x), .modrm(modrm), .sib(sib), .disp(disp),
    .regs(regs), .out_valid(out_valid), .base_out(base_out), .ea_out(ea_out),
    .disp_len(disp_len), .sib_present(sib_present), .invalid(invalid));

  task automatic model(output logic [63:0] eb, output logic [63:0] ee,
                       output logic [2:0] el, output logic es, output logic ei);
    int m = modrm[7:6];
    int r = modrm[2:0];
    int bcode, icode, sh;
    logic nob, useidx;
    logic [63:0] b, ix, d, s;
    es = (m != 3) && (r == 4);
    ei = (m == 3) || (mode64 && m == 0 && r == 5);
    bcode = es ? int'(sib[2:0]) : r;
    nob = (m == 0) && (bcode == 5);
    if (mode64 && rex_b) bcode += 8;
    icode = int'(sib[5:3]) + ((mode64 && rex_x) ? 8 : 0);
    useidx = es && icode != 4;
    sh = int'(sib[7:6]);
    b = nob ? 64'd0 : rf[bcode];
    ix = useidx ? rf[icode] * (64'd1 << sh) : 64'd0;
    if (m == 1) begin d = 64'(signed'(disp[7:0])); el = 1; end
    else if (m == 2 || nob) begin d = 64'(signed'(disp)); el = 4; end
    else begin d = 0; el = 0; end
    if (m == 3) el = 0;
    s = b + ix + d;
    if (!mode64) begin b = {32'd0, b[31:0]}; s = {32'd0, s[31:0]}; end
    eb = ei ? 64'd0 : b;
    ee = ei ? 64'd0 : s;
  endtask

  task automatic check(input string tag, input logic [63:0] eb, input logic [63:0] ee,
                       input logic [2:0] el, input logic es, input logic ei, input logic ev);
    checks++;
    if (base_out !== eb || ea_out !== ee || disp_len !== el || sib_present !== es ||
        invalid !== ei || out_valid !== ev) begin
      fails++;
      $display("FAIL %s: got v=%0b base=%h ea=%h len=%0d sib=%0b inv=%0b exp v=%0b base=%h ea=%h len=%0d sib=%0b inv=%0b",
               tag, out_valid, base_out, ea_out, disp_len, sib_present, invalid,
               ev, eb, ee, el, es, ei);
    end
  endtask

  task automatic op(input string tag, input logic m64, input logic rb, input logic rx,
                    input logic [7:0] mr, input logic [7:0] sb, input logic [31:0] dp);
    logic [63:0] eb, ee;
    logic [2:0] el;
    logic es, ei;
    @(negedge clk);
    mode64 = m64; rex_b = rb; rex_x = rx; modrm = mr; sib = sb; disp = dp; in_valid = 1;
    model(eb, ee, el, es, ei);
    @(negedge clk);
    in_valid = 0;
    check(tag, eb, ee, el, es, ei, 1'b1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) rf[i] = {$urandom, $urandom};
    rf[3] = 64'h0000_0000_ffff_fff0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", 64'd0, 64'd0, 3'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1;
    op("R2 mod0 rm1 64b", 1, 0, 0, 8'b00_000_001, 8'h00, 32'h0);
    op("R2 mod0 rm1 rex_b", 1, 1, 0, 8'b00_000_001, 8'h00, 32'h0);
    op("R3 sib base 6", 1, 1, 0, 8'b00_000_100, 8'b00_100_110, 32'h0);
    op("R4 sib base5 mod0 rex_b", 1, 1, 0, 8'b00_000_100, 8'b01_010_101, 32'hffff_fff8);
    op("R4 disp-only 32b", 0, 0, 0, 8'b00_000_101, 8'h00, 32'h1234_5678);
    op("R5 rip-relative 64b", 1, 0, 0, 8'b00_000_101, 8'h00, 32'h10);
    op("R5 mod3", 1, 0, 0, 8'b11_000_100, 8'h24, 32'h10);
    op("R6 no index", 1, 0, 0, 8'b00_000_100, 8'b11_100_000, 32'h0);
    op("R6 index 12 via rex_x", 1, 0, 1, 8'b00_000_100, 8'b11_100_000, 32'h0);
    op("R7 scale 8", 1, 0, 0, 8'b00_000_100, 8'b11_001_010, 32'h0);
    op("R8 disp8 negative", 1, 0, 0, 8'b01_000_010, 8'h00, 32'h0000_0080);
    op("R8 disp32 mod2", 1, 0, 0, 8'b10_000_010, 8'h00, 32'h8000_0000);
    op("R9 rex ignored wrap 32b", 0, 1, 1, 8'b01_000_011, 8'h00, 32'h0000_0020);
    op("R10 sib flag mod1", 1, 0, 0, 8'b01_000_100, 8'b00_001_011, 32'h7f);
    op("R11 full sum", 1, 1, 1, 8'b10_000_100, 8'b10_011_001, 32'h0000_1000);
    // R1 idle cycle drops valid and holds data
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got out_valid=%0b expected 0", out_valid);
    end
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) for (int i = 0; i < 16; i++) rf[i] = {$urandom, $urandom};
      op("R2/R3/R4/R6/R7/R8/R9/R10/R11 random", 1'($urandom), 1'($urandom), 1'($urandom),
         8'($urandom), 8'($urandom), $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule